// File: doc/BRIEF.md
# Passive Serial Configuration Sequencer

This block is the hardware master that loads a bitstream into a target FPGA over a two-wire passive serial link: one configuration clock and one data line. A start pulse latches the stream length. The block then drives its link outputs high, pulses the active-low configuration-start line, and waits for the target's status input to rise. It then pulls bytes from a ready/valid stream and shifts each one out a bit at a time.

While the stream runs, the block samples the status input at fixed byte intervals and once more after the final byte. When all bytes have gone out, it requires the done input to be high. It then gives a short run of extra clock pulses so that the target can finish initializing. At the end it checks status and done once more. The result is reported as a success flag or as a 3-bit code that names the failure point. A parameter selects whether each byte leaves least- or most-significant bit first. In the most-significant-first variant, a done input that is already high before the stream begins is treated as an error.

Top module: `psconf_loader`

## Requirements
- R1: After reset, `cfg_n`, `cfg_clk` and `cfg_data` are high, and `drive_en`, `busy`, `done_ok`, `in_ready` and `err_code` are all zero.
- R2: A start sets `drive_en` and `busy`. `cfg_n` then goes low for exactly `LOW_CYC` system cycles and returns high.
- R3: If `stat_in` stays low for `TMO_CYC` cycles after `cfg_n` returns high, the block stops with `err_code` 1 and sends no bits.
- R4: Each bit is sent as follows. `cfg_clk` is low for P cycles with `cfg_data` set to the bit, then high for P cycles. P is `phase_cycles`, or 1 when `phase_cycles` is 0. `cfg_data` does not change while `cfg_clk` stays high.
- R5: With `MSB_FIRST`=0, bit 0 of each byte is sent first. With `MSB_FIRST`=1, bit 7 is sent first.
- R6: A byte is accepted only when the shifter is idle and stream bytes remain. Exactly `byte_count` bytes are consumed on a clean run.
- R7: After every `CHK_EVERY`-th byte and after the final byte, `stat_in` is sampled once the byte has been shifted out. If it is low, the block stops with `err_code` 3 and takes no more bytes.
- R8: If `done_in` is low once the last byte has been shifted, the block stops with `err_code` 4 and issues no extra pulses.
- R9: When `done_in` is high after the stream, exactly `EXTRA_CLKS` more clock pulses follow. The block then requires both `stat_in` and `done_in` to be high: if so it sets `done_ok`, otherwise it reports `err_code` 5.
- R10: With `MSB_FIRST`=1, a high `done_in` at the moment the status input first reads high gives `err_code` 2 before any bit is sent. With `MSB_FIRST`=0, that condition is ignored.
- R11: `done_ok` and `err_code` hold after `busy` falls, until the next start clears them. Exactly one of them reports each finished run.
- R12: A `byte_count` of 0 moves directly from the status wait to the done check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a load when not busy |
| byte_count | input | COUNT_W | Stream length in bytes, latched at start |
| phase_cycles | input | PHASE_W | Length of each clock phase in system cycles (0 acts as 1) |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Block takes the byte this cycle |
| stat_in | input | 1 | Target status, high when healthy |
| done_in | input | 1 | Target configuration-complete flag |
| cfg_n | output | 1 | Active-low configuration start |
| cfg_clk | output | 1 | Serial configuration clock, target samples on rising edge |
| cfg_data | output | 1 | Serial configuration data |
| drive_en | output | 1 | Output enable for the link lines, set from the first start on |
| busy | output | 1 | Load in progress |
| done_ok | output | 1 | Last load finished successfully |
| err_code | output | 3 | 0 none, 1 status timeout, 2 done early, 3 stream status low, 4 done missing, 5 end check failed |

## Verification
The assertions assume that `start` arrives only while the block is idle and that `phase_cycles` and `byte_count` stay constant during a load. The bench changes them only between runs, after `busy` has fallen. They also assume that the target drives `stat_in` and `done_in` away from the clock edge. The bench's target model updates both on the falling edge, and `in_valid` is held high throughout, so only the block's `in_ready` paces the stream. Each scenario varies only the target model's timing knobs: status delay, the pulse count at which status drops, and done forced or gated.

// File: rtl/psconf_pkg.sv
package psconf_pkg;

    typedef enum logic [2:0] {
        ERR_NONE       = 3'd0,
        ERR_NO_STATUS  = 3'd1,
        ERR_EARLY_DONE = 3'd2,
        ERR_STREAM     = 3'd3,
        ERR_NO_DONE    = 3'd4,
        ERR_INIT_END   = 3'd5
    } err_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_PULSE,
        ST_WAIT,
        ST_STREAM,
        ST_CHECK,
        ST_TAIL
    } seq_e;

    function automatic logic [7:0] flip_byte(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psconf_shifter.sv
module psconf_shifter
    import psconf_pkg::*;
#(
    parameter int MSB_FIRST = 0,
    parameter int PHASE_W   = 8,
    parameter int BITS_W    = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [7:0]         load_byte,
    input  logic [BITS_W-1:0]  load_bits,
    input  logic [PHASE_W-1:0] phase_cycles,
    output logic               idle,
    output logic               ser_clk,
    output logic               ser_dat
);

    logic [7:0]         ordered;
    logic [7:0]         sh_q;
    logic [BITS_W-1:0]  left_q;
    logic [PHASE_W-1:0] cnt_q;
    logic [PHASE_W-1:0] half;
    logic               hi_q;
    logic               active_q;
    logic               clk_q;
    logic               dat_q;
    logic               phase_end;

    generate
        if (MSB_FIRST != 0) begin : g_msb
            assign ordered = flip_byte(load_byte);
        end else begin : g_lsb
            assign ordered = load_byte;
        end
    endgenerate

    assign half      = (phase_cycles == '0) ? PHASE_W'(1) : phase_cycles;
    assign phase_end = (cnt_q == half - PHASE_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '0;
            left_q   <= '0;
            cnt_q    <= '0;
            hi_q     <= 1'b0;
            active_q <= 1'b0;
            clk_q    <= 1'b1;
            dat_q    <= 1'b1;
        end else if (!active_q) begin
            if (load) begin
                active_q <= 1'b1;
                sh_q     <= ordered >> 1;
                dat_q    <= ordered[0];
                clk_q    <= 1'b0;
                hi_q     <= 1'b0;
                cnt_q    <= '0;
                left_q   <= load_bits;
            end
        end else if (!phase_end) begin
            cnt_q <= cnt_q + PHASE_W'(1);
        end else begin
            cnt_q <= '0;
            if (!hi_q) begin
                hi_q  <= 1'b1;
                clk_q <= 1'b1;
            end else if (left_q == BITS_W'(1)) begin
                active_q <= 1'b0;
            end else begin
                hi_q   <= 1'b0;
                clk_q  <= 1'b0;
                dat_q  <= sh_q[0];
                sh_q   <= sh_q >> 1;
                left_q <= left_q - BITS_W'(1);
            end
        end
    end

    assign idle    = !active_q;
    assign ser_clk = clk_q;
    assign ser_dat = dat_q;

    // R4: the target samples on the rising edge, so data must hold while clock is high
    assert_data_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_dat));

    // R4: a load always begins with the clock pulled low
    assert_load_low_R4: assert property (@(posedge clk) disable iff (rst)
        (load && idle) |=> !ser_clk);

endmodule

// File: rtl/psconf_ctrl.sv
module psconf_ctrl
    import psconf_pkg::*;
#(
    parameter int MSB_FIRST  = 0,
    parameter int COUNT_W    = 24,
    parameter int LOW_CYC    = 32,
    parameter int TMO_CYC    = 40000,
    parameter int CHK_EVERY  = 10240,
    parameter int EXTRA_CLKS = 50,
    parameter int BITS_W     = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [COUNT_W-1:0] byte_count,
    input  logic               in_valid,
    input  logic               stat_in,
    input  logic               done_in,
    input  logic               sh_idle,
    output logic               in_ready,
    output logic               sh_load,
    output logic               sh_tail,
    output logic [BITS_W-1:0]  sh_bits,
    output logic               cfg_n,
    output logic               drive_en,
    output logic               busy,
    output logic               done_ok,
    output err_e               err_code
);

    localparam int TMR_MAX = max_of(LOW_CYC, TMO_CYC);
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int CHK_W   = $clog2(CHK_EVERY + 1);

    seq_e               st_q;
    logic [TMR_W-1:0]   tmr_q;
    logic [COUNT_W-1:0] total_q;
    logic [COUNT_W-1:0] sent_q;
    logic [CHK_W-1:0]   seg_q;
    logic               pend_q;
    logic               busy_q;
    logic               ok_q;
    err_e               err_q;
    logic               cfgn_q;
    logic               en_q;
    logic               take;
    logic               seg_wrap;
    logic               last_byte;

    assign in_ready  = (st_q == ST_STREAM) && sh_idle && !pend_q && (sent_q != total_q);
    assign take      = in_ready && in_valid;
    assign sh_tail   = (st_q == ST_CHECK);
    assign sh_load   = take || (sh_tail && done_in);
    assign sh_bits   = sh_tail ? BITS_W'(EXTRA_CLKS) : BITS_W'(8);
    assign seg_wrap  = (seg_q == CHK_W'(CHK_EVERY - 1));
    assign last_byte = ((sent_q + COUNT_W'(1)) == total_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            tmr_q   <= '0;
            total_q <= '0;
            sent_q  <= '0;
            seg_q   <= '0;
            pend_q  <= 1'b0;
            busy_q  <= 1'b0;
            ok_q    <= 1'b0;
            err_q   <= ERR_NONE;
            cfgn_q  <= 1'b1;
            en_q    <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q    <= ST_ARM;
                        busy_q  <= 1'b1;
                        ok_q    <= 1'b0;
                        err_q   <= ERR_NONE;
                        en_q    <= 1'b1;
                        cfgn_q  <= 1'b1;
                        total_q <= byte_count;
                        sent_q  <= '0;
                        seg_q   <= '0;
                        pend_q  <= 1'b0;
                        tmr_q   <= '0;
                    end
                end
                ST_ARM: begin
                    cfgn_q <= 1'b0;
                    tmr_q  <= '0;
                    st_q   <= ST_PULSE;
                end
                ST_PULSE: begin
                    if (tmr_q == TMR_W'(LOW_CYC - 1)) begin
                        cfgn_q <= 1'b1;
                        tmr_q  <= '0;
                        st_q   <= ST_WAIT;
                    end else begin
                        tmr_q <= tmr_q + TMR_W'(1);
                    end
                end
                ST_WAIT: begin
                    if (stat_in) begin
                        if ((MSB_FIRST != 0) && done_in) begin
                            err_q  <= ERR_EARLY_DONE;
                            busy_q <= 1'b0;
                            st_q   <= ST_IDLE;
                        end else begin
                            st_q <= ST_STREAM;
                        end
                    end else if (tmr_q == TMR_W'(TMO_CYC - 1)) begin
                        err_q  <= ERR_NO_STATUS;
                        busy_q <= 1'b0;
                        st_q   <= ST_IDLE;
                    end else begin
                        tmr_q <= tmr_q + TMR_W'(1);
                    end
                end
                ST_STREAM: begin
                    if (take) begin
                        sent_q <= sent_q + COUNT_W'(1);
                        seg_q  <= seg_wrap ? '0 : seg_q + CHK_W'(1);
                        pend_q <= seg_wrap || last_byte;
                    end else if (pend_q && sh_idle) begin
                        pend_q <= 1'b0;
                        if (!stat_in) begin
                            err_q  <= ERR_STREAM;
                            busy_q <= 1'b0;
                            st_q   <= ST_IDLE;
                        end
                    end else if (!pend_q && sh_idle && (sent_q == total_q)) begin
                        st_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!done_in) begin
                        err_q  <= ERR_NO_DONE;
                        busy_q <= 1'b0;
                        st_q   <= ST_IDLE;
                    end else begin
                        st_q <= ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    if (sh_idle) begin
                        busy_q <= 1'b0;
                        st_q   <= ST_IDLE;
                        if (stat_in && done_in) ok_q  <= 1'b1;
                        else                    err_q <= ERR_INIT_END;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign cfg_n    = cfgn_q;
    assign drive_en = en_q;
    assign busy     = busy_q;
    assign done_ok  = ok_q;
    assign err_code = err_q;

    // R6: the consumed byte count never passes the latched length
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        sent_q <= total_q);

    // R11: a reported error means the block has stopped
    assert_err_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (err_q != ERR_NONE) |-> !busy_q);

    // R11: each finished run has exactly one outcome
    assert_one_outcome_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> (ok_q ^ (err_q != ERR_NONE)));

    // R9: success and an error code never coexist
    assert_ok_clean_R9: assert property (@(posedge clk) disable iff (rst)
        ok_q |-> (err_q == ERR_NONE));

endmodule

// File: rtl/psconf_loader.sv
module psconf_loader
    import psconf_pkg::*;
#(
    parameter int MSB_FIRST  = 0,
    parameter int COUNT_W    = 24,
    parameter int PHASE_W    = 8,
    parameter int LOW_CYC    = 32,
    parameter int TMO_CYC    = 40000,
    parameter int CHK_EVERY  = 10240,
    parameter int EXTRA_CLKS = 50
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [COUNT_W-1:0] byte_count,
    input  logic [PHASE_W-1:0] phase_cycles,
    input  logic [7:0]         in_data,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               stat_in,
    input  logic               done_in,
    output logic               cfg_n,
    output logic               cfg_clk,
    output logic               cfg_data,
    output logic               drive_en,
    output logic               busy,
    output logic               done_ok,
    output logic [2:0]         err_code
);

    localparam int BITS_W = $clog2(max_of(EXTRA_CLKS, 8) + 1);

    logic              sh_idle;
    logic              sh_load;
    logic              sh_tail;
    logic [BITS_W-1:0] sh_bits;
    logic [7:0]        sh_byte;
    err_e              err_e_w;

    psconf_ctrl #(
        .MSB_FIRST (MSB_FIRST),
        .COUNT_W   (COUNT_W),
        .LOW_CYC   (LOW_CYC),
        .TMO_CYC   (TMO_CYC),
        .CHK_EVERY (CHK_EVERY),
        .EXTRA_CLKS(EXTRA_CLKS),
        .BITS_W    (BITS_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .byte_count(byte_count),
        .in_valid  (in_valid),
        .stat_in   (stat_in),
        .done_in   (done_in),
        .sh_idle   (sh_idle),
        .in_ready  (in_ready),
        .sh_load   (sh_load),
        .sh_tail   (sh_tail),
        .sh_bits   (sh_bits),
        .cfg_n     (cfg_n),
        .drive_en  (drive_en),
        .busy      (busy),
        .done_ok   (done_ok),
        .err_code  (err_e_w)
    );

    assign sh_byte  = sh_tail ? 8'h00 : in_data;
    assign err_code = err_e_w;

    psconf_shifter #(
        .MSB_FIRST(MSB_FIRST),
        .PHASE_W  (PHASE_W),
        .BITS_W   (BITS_W)
    ) u_shift (
        .clk         (clk),
        .rst         (rst),
        .load        (sh_load),
        .load_byte   (sh_byte),
        .load_bits   (sh_bits),
        .phase_cycles(phase_cycles),
        .idle        (sh_idle),
        .ser_clk     (cfg_clk),
        .ser_dat     (cfg_data)
    );

    // R6: a byte is offered only between bits, with the link clock parked high
    assert_ready_parked_R6: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> cfg_clk);

    // R2: the start pulse only happens inside a load
    assert_pulse_busy_R2: assert property (@(posedge clk) disable iff (rst)
        !cfg_n |-> (busy && drive_en));

    // R3: no serial clocking before the target reports ready or after a stop
    assert_quiet_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cfg_clk);

endmodule

// File: tb/psconf_loader_tb.sv
module psconf_loader_tb;

    localparam int CLK_P   = 10;
    localparam int LOWC    = 4;
    localparam int TMOC    = 20;
    localparam int CHKE    = 4;
    localparam int EXTRA   = 5;
    localparam int RXN     = 1024;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] count = '0;
    logic [3:0] phase = 4'd1;
    logic       in_valid = 1'b1;
    logic       stat_in = 1'b0;
    logic       done_in = 1'b0;

    logic [7:0] data_l, data_m;
    logic ready_l, ready_m, cfgn_l, cfgn_m, sclk_l, sclk_m, sdat_l, sdat_m;
    logic en_l, en_m, busy_l, busy_m, ok_l, ok_m;
    logic [2:0] err_l, err_m;

    int checks = 0;
    int errs   = 0;
    bit finished = 0;

    // target model knobs
    int  stat_delay = -1;
    int  stat_drop  = -1;
    int  n_bytes    = 0;
    bit  done_en    = 0;
    bit  done_force = 0;
    bit  clear_req  = 0;

    // target model observations
    int  since, edges_l, edges_m, gap_l, last_rise, cyc, low_len, idx_l, idx_m;
    bit  rx_l [RXN];
    bit  rx_m [RXN];
    logic pclk_l, pclk_m;

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [7:0] fbyte(input int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    assign data_l = fbyte(idx_l);
    assign data_m = fbyte(idx_m);

    psconf_loader #(
        .MSB_FIRST(0), .COUNT_W(8), .PHASE_W(4), .LOW_CYC(LOWC),
        .TMO_CYC(TMOC), .CHK_EVERY(CHKE), .EXTRA_CLKS(EXTRA)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start), .byte_count(count), .phase_cycles(phase),
        .in_data(data_l), .in_valid(in_valid), .in_ready(ready_l),
        .stat_in(stat_in), .done_in(done_in), .cfg_n(cfgn_l), .cfg_clk(sclk_l),
        .cfg_data(sdat_l), .drive_en(en_l), .busy(busy_l), .done_ok(ok_l), .err_code(err_l)
    );

    psconf_loader #(
        .MSB_FIRST(1), .COUNT_W(8), .PHASE_W(4), .LOW_CYC(LOWC),
        .TMO_CYC(TMOC), .CHK_EVERY(CHKE), .EXTRA_CLKS(EXTRA)
    ) u_dut_msb (
        .clk(clk), .rst(rst), .start(start), .byte_count(count), .phase_cycles(phase),
        .in_data(data_m), .in_valid(in_valid), .in_ready(ready_m),
        .stat_in(stat_in), .done_in(done_in), .cfg_n(cfgn_m), .cfg_clk(sclk_m),
        .cfg_data(sdat_m), .drive_en(en_m), .busy(busy_m), .done_ok(ok_m), .err_code(err_m)
    );

    // stream source: advance on each accepted byte
    always @(posedge clk) begin
        if (rst || clear_req) begin
            idx_l <= 0;
            idx_m <= 0;
        end else begin
            if (ready_l && in_valid) idx_l <= idx_l + 1;
            if (ready_m && in_valid) idx_m <= idx_m + 1;
        end
    end

    // target model, evaluated away from the active edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst || clear_req) begin
            since = 0; edges_l = 0; edges_m = 0; gap_l = 0; last_rise = cyc; low_len = 0;
        end else begin
            if (!cfgn_l) begin
                since = 0;
                low_len = low_len + 1;
            end else begin
                since = since + 1;
            end
            if (!pclk_l && sclk_l) begin
                if (edges_l < RXN) rx_l[edges_l] = sdat_l;
                edges_l = edges_l + 1;
                gap_l = cyc - last_rise;
                last_rise = cyc;
            end
            if (!pclk_m && sclk_m) begin
                if (edges_m < RXN) rx_m[edges_m] = sdat_m;
                edges_m = edges_m + 1;
            end
        end
        pclk_l = sclk_l;
        pclk_m = sclk_m;
        stat_in = cfgn_l && (stat_delay >= 0) && (since >= stat_delay) &&
                  !((stat_drop >= 0) && (edges_l >= stat_drop));
        done_in = done_force || (done_en && (edges_l >= 8 * n_bytes));
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int n, input int ph, input int sdel, input int sdrop,
                       input bit den, input bit dforce);
        @(negedge clk);
        stat_delay = sdel; stat_drop = sdrop; n_bytes = n;
        done_en = den; done_force = dforce; clear_req = 1;
        @(negedge clk);
        clear_req = 0;
        count = 8'(n);
        phase = 4'(ph);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11 busy after start", int'(busy_l), 1);
        chk("R11 err cleared at start", int'(err_l), 0);
        chk("R11 ok cleared at start", int'(ok_l), 0);
        for (int i = 0; i < 5000; i++) begin
            if (!busy_l && !busy_m) break;
            @(negedge clk);
        end
        chk("R11 run finished", int'(busy_l || busy_m), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_bytes(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            logic [7:0] al, am;
            for (int i = 0; i < 8; i++) begin
                al[i]   = rx_l[k*8 + i];
                am[7-i] = rx_m[k*8 + i];
            end
            chk({req, " lsb-first byte"}, int'(al), int'(fbyte(k)));
            chk({req, " msb-first byte"}, int'(am), int'(fbyte(k)));
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        cyc = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 cfg_n", int'(cfgn_l), 1);
        chk("R1 cfg_clk", int'(sclk_l), 1);
        chk("R1 cfg_data", int'(sdat_l), 1);
        chk("R1 drive_en", int'(en_l), 0);
        chk("R1 busy", int'(busy_l), 0);
        chk("R1 done_ok", int'(ok_l), 0);
        chk("R1 in_ready", int'(ready_l), 0);
        chk("R1 err_code", int'(err_m), 0);

        // clean load, fast clock: R2 R4 R5 R6 R9
        run(6, 1, 3, -1, 1, 0);
        chk("R2 drive_en", int'(en_l), 1);
        chk("R2 cfg_n low length", low_len, LOWC);
        chk("R9 done_ok lsb", int'(ok_l), 1);
        chk("R9 done_ok msb", int'(ok_m), 1);
        chk("R9 pulses incl extra", edges_l, 6*8 + EXTRA);
        chk("R4 bit period P=1", gap_l, 2);
        chk("R6 bytes consumed", idx_l, 6);
        check_bytes(6, "R5");

        // slower clock, two interval checkpoints: R4 R7
        run(9, 3, 0, -1, 1, 0);
        chk("R7 clean checkpoints ok", int'(ok_l), 1);
        chk("R4 bit period P=3", gap_l, 6);
        chk("R9 pulses msb", edges_m, 9*8 + EXTRA);
        chk("R6 bytes consumed msb", idx_m, 9);
        check_bytes(9, "R5");

        // phase 0 acts as 1: R4
        run(2, 0, 1, -1, 1, 0);
        chk("R4 phase zero period", gap_l, 2);
        chk("R4 phase zero ok", int'(ok_l), 1);

        // status never high: R3
        run(3, 1, -1, -1, 1, 0);
        chk("R3 err lsb", int'(err_l), 1);
        chk("R3 err msb", int'(err_m), 1);
        chk("R3 no bits", edges_l, 0);
        chk("R3 no bytes", idx_l, 0);
        repeat (20) @(negedge clk);
        chk("R11 err held", int'(err_l), 1);
        chk("R11 ok stays low", int'(ok_l), 0);

        // done already high: R10
        run(3, 1, 2, -1, 0, 1);
        chk("R10 msb early done", int'(err_m), 2);
        chk("R10 msb no bits", edges_m, 0);
        chk("R10 lsb ignores", int'(ok_l), 1);
        chk("R10 lsb pulses", edges_l, 3*8 + EXTRA);

        // status drop caught at interval checkpoint 8: R7
        run(10, 1, 1, 41, 1, 0);
        chk("R7 interval err", int'(err_l), 3);
        chk("R7 interval err msb", int'(err_m), 3);
        chk("R7 bytes before stop", idx_l, 8);
        chk("R7 pulses before stop", edges_l, 64);

        // status drop caught at final byte: R7
        run(6, 1, 1, 44, 1, 0);
        chk("R7 final err", int'(err_l), 3);
        chk("R7 final bytes", idx_l, 6);
        chk("R7 final no extra", edges_l, 48);

        // done missing: R8
        run(5, 2, 1, -1, 0, 0);
        chk("R8 err", int'(err_l), 4);
        chk("R8 no extra pulses", edges_l, 40);

        // status drop during extra pulses: R9
        run(4, 1, 1, 34, 1, 0);
        chk("R9 end check err", int'(err_l), 5);
        chk("R9 end check err msb", int'(err_m), 5);
        chk("R9 all extra sent", edges_l, 32 + EXTRA);
        chk("R9 ok low on fail", int'(ok_l), 0);

        // zero length: R12
        run(0, 1, 1, -1, 0, 0);
        chk("R12 zero no done", int'(err_l), 4);
        chk("R12 zero no bits", edges_l, 0);
        run(0, 1, 1, -1, 1, 0);
        chk("R12 zero ok lsb", int'(ok_l), 1);
        chk("R12 zero extra only", edges_l, EXTRA);
        chk("R12 zero msb early done", int'(err_m), 2);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule